// File: doc/BRIEF.md
# Interrupt Flag and Watchdog Kick Register

This block is a single byte-wide register on a special-function-register bus. It holds two interrupt flags: one that marks a transfer-busy event and one that marks a PLL-fall event. The same byte is also the control point that restarts the watchdog. Hardware event pulses set the flags. Software clears them with full-byte writes. Software writes a 1 in every bit it wants to keep and a 0 in every flag it wants to clear.

Bit 7 has a different meaning for reads and for writes. A read of bit 7 returns the PLL-fall flag. A write of 0 to bit 7 clears that flag. A write of 1 to bit 7 does not touch the flag and instead sends a one-cycle restart pulse to the watchdog. A small down-counting watchdog is included so that the restart path can be observed end to end. Both flag levels are brought out for an interrupt controller.

Top module: `evt_flag_kick`

## Requirements
- R1: After reset both flags are 0, the register reads 0x00 when selected, `wdogKick` and `wdogTimeout` are low, and the watchdog counter holds its reload value.
- R2: A pulse on `xferEvt` sets the transfer flag (bit 0, also `xferFlag`) at the next clock edge.
- R3: A write to the register with bit 0 = 0 clears the transfer flag at the next edge. A write with bit 0 = 1 leaves it unchanged, so software can never set it.
- R4: A pulse on `pllFallEvt` sets the PLL-fall flag at the next edge. That flag is read back in bit 7 and is also driven on `pllFlag`.
- R5: A write with bit 7 = 0 clears the PLL-fall flag at the next edge and does not restart the watchdog.
- R6: A write with bit 7 = 1 makes `wdogKick` high for exactly the cycle after the write edge, and leaves the PLL-fall flag unchanged.
- R7: When a set event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: Bits 1 to 6 always read 0. `sfrRdData` is 0x00 whenever `sfrAddr` does not match the register address. Writes to other addresses change nothing.
- R9: Without a restart, the watchdog counts down by one each cycle from its reload value. `wdogTimeout` is high for exactly one cycle while the count is 0, and the counter then reloads. This gives one timeout every RELOAD+1 cycles.
- R10: A `wdogKick` pulse reloads the watchdog counter at the next edge and suppresses any timeout in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrAddr | input | ADDR_W | Register bus address |
| sfrWrEn | input | 1 | Register bus write strobe |
| sfrWrData | input | 8 | Register bus write data |
| sfrRdData | output | 8 | Read data, combinational on address |
| xferEvt | input | 1 | Transfer-busy event pulse |
| pllFallEvt | input | 1 | PLL-fall event pulse |
| xferFlag | output | 1 | Transfer interrupt flag level |
| pllFlag | output | 1 | PLL-fall interrupt flag level |
| wdogKick | output | 1 | One-cycle watchdog restart pulse |
| wdogTimeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The bench targets the cycle in which a set event meets a clearing write. A design where the clear wins would lose that interrupt, and the bench would see the flag go low. It writes 0xFF to confirm that the write-0-to-clear rule holds. A design that copies the written bits would set the transfer flag, and one that wrongly decodes bit 7 would clear the PLL-fall flag or miss the kick. It also measures the spacing of timeouts with and without kicks, which exposes off-by-one reload counts, timeouts that last more than one cycle, and a kick that fails to reload the counter. Writes to foreign addresses and reads of the reserved bits check that nothing leaks through the decode.

// File: rtl/evt_flag_kick_pkg.sv
package evt_flag_kick_pkg;
  localparam int DATA_W   = 8;
  localparam int XFER_BIT = 0;
  localparam int PLL_BIT  = 7;

  typedef struct packed {
    logic clrXfer;
    logic clrPll;
    logic rdSel;
  } flagStrobes_t;
endpackage

// File: rtl/evt_flag_ctrl.sv
module evt_flag_ctrl
  import evt_flag_kick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic [DATA_W-1:0] sfrWrData,
  output flagStrobes_t      strobes,
  output logic              wdogKick
);
  logic regHit;
  logic regWr;
  logic kickReq;
  logic unusedWrBits;

  assign regHit       = (sfrAddr == REG_ADDR);
  assign regWr        = regHit && sfrWrEn;
  assign kickReq      = regWr && sfrWrData[PLL_BIT];
  assign unusedWrBits = ^sfrWrData;

  always_comb begin
    strobes.rdSel   = regHit;
    strobes.clrXfer = regWr && !sfrWrData[XFER_BIT];
    strobes.clrPll  = regWr && !sfrWrData[PLL_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) wdogKick <= 1'b0;
    else       wdogKick <= kickReq;
  end

  // R6 / R5: the kick follows a bit-7=1 write and never a bit-7=0 one
  assert_kick_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && sfrWrData[PLL_BIT]) |=> wdogKick);
  assert_no_kick_on_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && sfrWrData[PLL_BIT]) |=> !wdogKick);
endmodule

// File: rtl/evt_flag_dp.sv
module evt_flag_dp
  import evt_flag_kick_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobes_t      strobes,
  input  logic              xferEvt,
  input  logic              pllFallEvt,
  output logic              xferFlag,
  output logic              pllFlag,
  output logic [DATA_W-1:0] sfrRdData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferFlag <= 1'b0;
      pllFlag  <= 1'b0;
    end else begin
      // a set event outranks a clear in the same cycle
      xferFlag <= xferEvt    || (xferFlag && !strobes.clrXfer);
      pllFlag  <= pllFallEvt || (pllFlag  && !strobes.clrPll);
    end
  end

  always_comb begin
    sfrRdData = '0;
    if (strobes.rdSel) begin
      sfrRdData[XFER_BIT] = xferFlag;
      sfrRdData[PLL_BIT]  = pllFlag;
    end
  end

  assert_xfer_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    xferEvt |=> xferFlag);
  assert_pll_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pllFallEvt && strobes.clrPll) |=> pllFlag);
  assert_xfer_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrXfer && !xferEvt) |=> !xferFlag);
  assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clrXfer && !xferEvt) |=> $stable(xferFlag));
  assert_pll_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clrPll && !pllFallEvt) |=> $stable(pllFlag));
endmodule

// File: rtl/evt_wdog.sv
module evt_wdog #(
  parameter int CNT_W  = 16,
  parameter int RELOAD = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic kick,
  output logic timeout
);
  localparam logic [CNT_W-1:0] RELOAD_V = CNT_W'(RELOAD);

  logic [CNT_W-1:0] count;

  assign timeout = (count == '0) && !kick;

  always_ff @(posedge clk) begin
    if (!rstN)               count <= RELOAD_V;
    else if (kick)           count <= RELOAD_V;
    else if (count == '0)    count <= RELOAD_V;
    else                     count <= count - 1'b1;
  end

  assert_reload_on_kick_R10: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> (count == RELOAD_V));
  assert_reload_after_expiry_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> (count == RELOAD_V) && !timeout);
  assert_count_down_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!kick && count != '0) |=> (count == $past(count) - 1'b1));
  assert_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    count <= RELOAD_V);
endmodule

// File: rtl/evt_flag_kick.sv
module evt_flag_kick
  import evt_flag_kick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40,
  parameter int CNT_W  = 16,
  parameter int RELOAD = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic [DATA_W-1:0] sfrWrData,
  output logic [DATA_W-1:0] sfrRdData,
  input  logic              xferEvt,
  input  logic              pllFallEvt,
  output logic              xferFlag,
  output logic              pllFlag,
  output logic              wdogKick,
  output logic              wdogTimeout
);
  flagStrobes_t strobes;

  evt_flag_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .strobes(strobes), .wdogKick(wdogKick)
  );

  evt_flag_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .xferEvt(xferEvt),
    .pllFallEvt(pllFallEvt), .xferFlag(xferFlag), .pllFlag(pllFlag),
    .sfrRdData(sfrRdData)
  );

  evt_wdog #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_wdog (
    .clk(clk), .rstN(rstN), .kick(wdogKick), .timeout(wdogTimeout)
  );

  // R1: nothing pulses in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    !rstN |=> !wdogKick && !xferFlag && !pllFlag);
endmodule

// File: tb/evt_flag_kick_tb.sv
module evt_flag_kick_tb;
  localparam int ADDR_W = 8;
  localparam logic [7:0] REG_A = 8'h40;
  localparam int RELOAD = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic sfrWrEn = 1'b0;
  logic [7:0] sfrWrData = 8'h00;
  logic xferEvt = 1'b0;
  logic pllFallEvt = 1'b0;
  logic [7:0] sfrRdData;
  logic xferFlag, pllFlag, wdogKick, wdogTimeout;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_flag_kick #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A), .CNT_W(8), .RELOAD(RELOAD)) u_dut (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .xferEvt(xferEvt),
    .pllFallEvt(pllFallEvt), .xferFlag(xferFlag), .pllFlag(pllFlag),
    .wdogKick(wdogKick), .wdogTimeout(wdogTimeout)
  );

  // reference model, updated on the same edges
  bit mXfer, mPll, mKick;
  int mCnt;

  function automatic bit nextFlag(bit cur, bit setEv, bit clr);
    return setEv | (cur & ~clr);
  endfunction

  function automatic logic [7:0] expRead(bit sel, bit x, bit p);
    return sel ? {p, 6'b000000, x} : 8'h00;
  endfunction

  always @(posedge clk) begin
    bit wr;
    wr = sfrWrEn && (sfrAddr == REG_A);
    if (!rstN) begin
      mXfer = 0; mPll = 0; mKick = 0; mCnt = RELOAD;
    end else begin
      if (mKick || mCnt == 0) mCnt = RELOAD; else mCnt = mCnt - 1;
      mXfer = nextFlag(mXfer, xferEvt, wr && !sfrWrData[0]);
      mPll  = nextFlag(mPll, pllFallEvt, wr && !sfrWrData[7]);
      mKick = wr && sfrWrData[7];
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R2/R3/R7 xferFlag", {7'b0, xferFlag}, {7'b0, mXfer});
    chk("R4/R5/R7 pllFlag", {7'b0, pllFlag}, {7'b0, mPll});
    chk("R4/R8 sfrRdData", sfrRdData, expRead(sfrAddr == REG_A, mXfer, mPll));
    chk("R6 wdogKick", {7'b0, wdogKick}, {7'b0, mKick});
    chk("R9/R10 wdogTimeout", {7'b0, wdogTimeout},
        {7'b0, (mCnt == 0) && !mKick});
  endtask

  // check state after the previous edge, then drive the next inputs
  task automatic step(logic [7:0] a, bit we, logic [7:0] d, bit xe, bit pe);
    @(negedge clk);
    if (rstN) checkAll();
    sfrAddr = a; sfrWrEn = we; sfrWrData = d; xferEvt = xe; pllFallEvt = pe;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(REG_A, 0, 8'h00, 0, 0);
  endtask

  initial begin
    int seed;
    int tmoSeen;
    seed = 32'h1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 read after reset", sfrRdData, 8'h00);
    chk("R1 kick after reset", {7'b0, wdogKick}, 8'h00);
    chk("R1 timeout after reset", {7'b0, wdogTimeout}, 8'h00);
    // R2 set, R3 write-1 keeps, R3 write-0 clears
    step(REG_A, 0, 8'h00, 1, 0);
    step(REG_A, 1, 8'h7F, 0, 0);
    step(REG_A, 0, 8'h00, 0, 0);
    chk("R3 write 1 keeps xfer", {7'b0, xferFlag}, 8'h01);
    step(REG_A, 1, 8'h7E, 0, 0);
    step(REG_A, 0, 8'h00, 0, 0);
    chk("R3 write 0 clears xfer", {7'b0, xferFlag}, 8'h00);
    step(REG_A, 1, 8'hFF, 0, 0);  // R3: cannot set by writing 1
    // R4 pll set and readback
    step(REG_A, 0, 8'h00, 0, 1);
    step(REG_A, 0, 8'h00, 0, 0);
    chk("R4 bit7 reads pll", sfrRdData, 8'h80);
    // R6 kick leaves pll
    step(REG_A, 1, 8'hFF, 0, 0);
    step(REG_A, 0, 8'h00, 0, 0);
    chk("R6 kick pulse", {7'b0, wdogKick}, 8'h01);
    chk("R6 pll kept", {7'b0, pllFlag}, 8'h01);
    // R8 foreign address write ignored
    step(8'h41, 1, 8'h00, 0, 0);
    step(8'h41, 0, 8'h00, 0, 0);
    chk("R8 foreign read zero", sfrRdData, 8'h00);
    chk("R8 pll survives foreign write", {7'b0, pllFlag}, 8'h01);
    // R5 clear pll, no kick
    step(REG_A, 1, 8'h7F, 0, 0);
    step(REG_A, 0, 8'h00, 0, 0);
    chk("R5 pll cleared", {7'b0, pllFlag}, 8'h00);
    chk("R5 no kick", {7'b0, wdogKick}, 8'h00);
    // R7 set beats clear
    step(REG_A, 1, 8'h00, 1, 1);
    step(REG_A, 0, 8'h00, 0, 0);
    chk("R7 both set win", sfrRdData, 8'h81);
    step(REG_A, 1, 8'h7E, 0, 0);
    // R9 free run: count timeouts over 3 periods
    tmoSeen = 0;
    for (int i = 0; i < 3 * (RELOAD + 1); i++) begin
      step(REG_A, 0, 8'h00, 0, 0);
      if (wdogTimeout) tmoSeen++;
    end
    chk("R9 timeouts per 3 periods", 8'(tmoSeen), 8'd3);
    // R10 frequent kicks stop timeouts
    tmoSeen = 0;
    for (int i = 0; i < 100; i++) begin
      step(REG_A, (i % 10) == 0, 8'hFF, 0, 0);
      if (wdogTimeout) tmoSeen++;
    end
    chk("R10 no timeout with kicks", 8'(tmoSeen), 8'd0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : REG_A;
      step(a, ($urandom % 8) == 0, 8'($urandom),
           ($urandom % 6) == 0, ($urandom % 7) == 0);
      if ($urandom % 500 == 0) begin
        @(negedge clk); rstN = 1'b0;
        @(negedge clk); rstN = 1'b1;
      end
    end
    idle(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule